// File: doc/BRIEF.md
# Raster Line Counter with Sync Status

This block tracks the scan position of a video raster, one step per dot clock. A dot counter runs across each line, a line counter steps at the end of every line and returns to zero at the end of the frame, and a field flag inverts on every frame wrap while interlace is switched on. All timing values are counted in dot clocks.

Software-style configuration arrives on a single-cycle write port carrying an index and a 32-bit data word. Four values can be written: the frame geometry (line count and line length), the sync configuration (interlace), the sync timing (vertical sync line count and horizontal sync width) and the front porch. The back porch is a fixed parameter.

The block drives a packed status word built from the current line, the field parity and three flags: display active, horizontal sync released and vertical sync released. The flags are decided differently depending on whether the parity of the current line equals the field flag. A one-cycle frame-start pulse marks the moment the raster enters line 42.

Top module: `raster_sync_timer`

## Requirements
- R1: After reset the geometry word is 0x0270035F (625 lines of 864 dots), the timing word is 0x07D6A53F (vertical sync count 5, horizontal sync code 63), interlace is off, the front porch code is 0, the raster sits at line 0 dot 0 with the field flag clear, and `status_word` reads 0.
- R2: The dot position advances by one each clock; on the clock where it equals dots-minus-one it returns to 0 and the line advances by one, and a line at or above lines-minus-one returns to 0 instead.
- R3: When the line wraps to 0 the field flag inverts if interlace (bit 4 of the sync configuration word) is set, and holds otherwise.
- R4: The geometry word carries lines-minus-one in bits 25:16 and dots-minus-one in bits 9:0 (other bits dropped); a write to it sets the dot position to 0 on that clock while the line and the field flag keep their values.
- R5: `status_word` bits 9:0 show the current line and bit 10 shows the field flag (1 = odd field).
- R6: When the line parity (line bit 0) equals the field flag: bit 12 is set while the dot position exceeds (hsync code + 1) x 2; if the line is at or above the vertical sync count, bit 13 is set and bit 11 is set while the dot position exceeds front porch code + 1.
- R7: When the line parity differs from the field flag: if the line is at or above the vertical sync count, bits 12 and 13 are set and bit 11 is set while dot position + back porch < dots per line; otherwise bit 12 is the only flag set. The timing word carries the vertical sync count in bits 11:8 and the hsync code in bits 6:0; the front porch code sits in bits 9:0 of its own word.
- R8: `frame_start` is high for exactly the one cycle in which the raster has just entered line 42 at dot 0; a frame with 42 lines or fewer never raises it.
- R9: Write index 0 is the geometry word, 1 the sync configuration, 2 the sync timing and 3 the front porch; writes to any other index change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 3 | Register index of the write |
| wr_data | input | 32 | Register write data |
| status_word | output | 14 | Packed line, field and sync flags |
| frame_start | output | 1 | One-cycle pulse on entry to line 42 |

## Verification
The bench drives the geometry down to small frames so that many wraps, field flips and frame pulses occur, and checks every cycle against a behavioural raster model, so a counter that wrapped one line or one dot late would drift the line field at once. It runs frames shorter than 42 lines, where a pulse tied to the wrap instead of the line value would fire, and a line length shorter than the back porch, where an unsigned subtraction would wrap and mark odd-parity lines active. It rewrites the geometry mid-line to catch a design that clears the line or the field with the dot counter, toggles interlace off after an odd field to catch a field flag that resets instead of holding, and writes unused indices whose data would collapse the frame if decoded.

// File: rtl/raster_pkg.sv
package raster_pkg;
   localparam int CNT_W  = 10;   // line and dot field width
   localparam int VS_W   = 4;
   localparam int HS_W   = 7;
   localparam int DATA_W = 32;
   localparam int STAT_W = 14;

   // field positions inside the write words
   localparam int GEO_LINES_LSB = 16;
   localparam int GEO_DOTS_LSB  = 0;
   localparam int TIM_VS_LSB    = 8;
   localparam int TIM_HS_LSB    = 0;
   localparam int SCFG_IL_BIT   = 4;

   // status word bit positions
   localparam int ST_FIELD  = 10;
   localparam int ST_ACTIVE = 11;
   localparam int ST_NOHS   = 12;
   localparam int ST_NOVS   = 13;

   // write indices
   localparam int IDX_GEO   = 0;
   localparam int IDX_SCFG  = 1;
   localparam int IDX_TIM   = 2;
   localparam int IDX_PORCH = 3;

   typedef struct packed {
      logic [CNT_W-1:0] lines_m1;
      logic [CNT_W-1:0] dots_m1;
      logic [VS_W-1:0]  vs_lines;
      logic [HS_W-1:0]  hs_code;
      logic [CNT_W-1:0] fp_code;
      logic             interlace;
   } raster_cfg_t;
endpackage

// File: rtl/raster_cfg_regs.sv
module raster_cfg_regs
   import raster_pkg::*;
#(
   parameter int          ADDR_W    = 3,
   parameter logic [31:0] GEO_RST   = 32'h0270_035F,
   parameter logic [31:0] SCFG_RST  = 32'h0000_0000,
   parameter logic [31:0] TIM_RST   = 32'h07D6_A53F,
   parameter logic [31:0] PORCH_RST = 32'h0000_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output raster_cfg_t       cfg,
   output logic              geo_wr
);
   localparam logic [ADDR_W-1:0] A_GEO   = ADDR_W'(IDX_GEO);
   localparam logic [ADDR_W-1:0] A_SCFG  = ADDR_W'(IDX_SCFG);
   localparam logic [ADDR_W-1:0] A_TIM   = ADDR_W'(IDX_TIM);
   localparam logic [ADDR_W-1:0] A_PORCH = ADDR_W'(IDX_PORCH);

   initial begin
      if (ADDR_W < 2) $fatal(1, "raster_cfg_regs: ADDR_W must be at least 2");
   end

   logic unused_wr_bits;
   assign unused_wr_bits = ^{wr_data[31:26], wr_data[15:12], wr_data[7]};

   assign geo_wr = wr_en && (wr_addr == A_GEO);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg.lines_m1  <= GEO_RST[GEO_LINES_LSB +: CNT_W];
         cfg.dots_m1   <= GEO_RST[GEO_DOTS_LSB +: CNT_W];
         cfg.interlace <= SCFG_RST[SCFG_IL_BIT];
         cfg.vs_lines  <= TIM_RST[TIM_VS_LSB +: VS_W];
         cfg.hs_code   <= TIM_RST[TIM_HS_LSB +: HS_W];
         cfg.fp_code   <= PORCH_RST[CNT_W-1:0];
      end else if (wr_en) begin
         unique case (wr_addr)
            A_GEO: begin
               cfg.lines_m1 <= wr_data[GEO_LINES_LSB +: CNT_W];
               cfg.dots_m1  <= wr_data[GEO_DOTS_LSB +: CNT_W];
            end
            A_SCFG:  cfg.interlace <= wr_data[SCFG_IL_BIT];
            A_TIM: begin
               cfg.vs_lines <= wr_data[TIM_VS_LSB +: VS_W];
               cfg.hs_code  <= wr_data[TIM_HS_LSB +: HS_W];
            end
            A_PORCH: cfg.fp_code <= wr_data[CNT_W-1:0];
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/raster_counter.sv
module raster_counter
   import raster_pkg::*;
#(
   parameter int FRAME_LINE = 42
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] lines_m1,
   input  logic [CNT_W-1:0] dots_m1,
   input  logic             interlace,
   input  logic             geo_wr,
   output logic [CNT_W-1:0] line,
   output logic [CNT_W-1:0] pos,
   output logic             field,
   output logic             frame_start
);
   localparam logic [CNT_W-1:0] MARK_LINE = CNT_W'(FRAME_LINE);

   initial begin
      if (FRAME_LINE < 0 || FRAME_LINE >= (1 << CNT_W))
         $fatal(1, "raster_counter: FRAME_LINE out of range");
   end

   logic             line_end;
   logic             frame_wrap;
   logic [CNT_W-1:0] line_nxt;

   always_comb begin
      line_end   = (pos >= dots_m1);
      frame_wrap = (line >= lines_m1);
      line_nxt   = line;
      if (line_end) line_nxt = frame_wrap ? '0 : line + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos         <= '0;
         line        <= '0;
         field       <= 1'b0;
         frame_start <= 1'b0;
      end else if (geo_wr) begin
         pos         <= '0;
         frame_start <= 1'b0;
      end else begin
         pos         <= line_end ? '0 : pos + 1'b1;
         line        <= line_nxt;
         frame_start <= line_end && (line_nxt == MARK_LINE);
         if (line_end && frame_wrap && interlace) field <= ~field;
      end
   end
endmodule

// File: rtl/raster_status.sv
module raster_status
   import raster_pkg::*;
#(
   parameter int BACK_PORCH = 8,
   parameter int HS_UNIT    = 2
) (
   input  logic [CNT_W-1:0] line,
   input  logic [CNT_W-1:0] pos,
   input  logic             field,
   input  logic [CNT_W-1:0] dots_m1,
   input  logic [VS_W-1:0]  vs_lines,
   input  logic [HS_W-1:0]  hs_code,
   input  logic [CNT_W-1:0] fp_code,
   output logic [STAT_W-1:0] status
);
   localparam int CMP_W = CNT_W + 2;
   localparam logic [CMP_W-1:0] BP_W   = CMP_W'(BACK_PORCH);
   localparam logic [CMP_W-1:0] UNIT_W = CMP_W'(HS_UNIT);

   initial begin
      if (HS_UNIT < 1 || HS_UNIT * (1 << HS_W) >= (1 << CMP_W))
         $fatal(1, "raster_status: HS_UNIT out of range");
      if (BACK_PORCH < 0 || BACK_PORCH >= (1 << CNT_W))
         $fatal(1, "raster_status: BACK_PORCH out of range");
   end

   logic [CMP_W-1:0] pos_w, hs_dots, fp_dots, line_dots;
   logic             same_parity, below_vs;
   logic             past_hs, past_fp, before_bp;

   always_comb begin
      pos_w       = CMP_W'(pos);
      hs_dots     = (CMP_W'(hs_code) + 1'b1) * UNIT_W;
      fp_dots     = CMP_W'(fp_code) + 1'b1;
      line_dots   = CMP_W'(dots_m1) + 1'b1;
      same_parity = (line[0] == field);
      below_vs    = (line < CNT_W'(vs_lines));
      past_hs     = (pos_w > hs_dots);
      past_fp     = (pos_w > fp_dots);
      before_bp   = ((pos_w + BP_W) < line_dots);

      status            = '0;
      status[CNT_W-1:0] = line;
      status[ST_FIELD]  = field;
      if (same_parity) begin
         status[ST_NOHS] = past_hs;
         if (!below_vs) begin
            status[ST_NOVS]   = 1'b1;
            status[ST_ACTIVE] = past_fp;
         end
      end else begin
         status[ST_NOHS] = 1'b1;
         if (!below_vs) begin
            status[ST_NOVS]   = 1'b1;
            status[ST_ACTIVE] = before_bp;
         end
      end
   end
endmodule

// File: rtl/raster_sync_timer.sv
module raster_sync_timer
   import raster_pkg::*;
#(
   parameter int          ADDR_W     = 3,
   parameter int          FRAME_LINE = 42,
   parameter int          BACK_PORCH = 8,
   parameter int          HS_UNIT    = 2,
   parameter bit          STATUS_REG = 1'b0,
   parameter logic [31:0] GEO_RST    = 32'h0270_035F,
   parameter logic [31:0] TIM_RST    = 32'h07D6_A53F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [31:0]       wr_data,
   output logic [13:0]       status_word,
   output logic              frame_start
);
   raster_cfg_t      cfg_q;
   logic             geo_wr;
   logic [CNT_W-1:0] line_q, pos_q;
   logic             field_q;
   logic [STAT_W-1:0] status_raw;

   raster_cfg_regs #(
      .ADDR_W  (ADDR_W),
      .GEO_RST (GEO_RST),
      .TIM_RST (TIM_RST)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .cfg     (cfg_q),
      .geo_wr  (geo_wr)
   );

   raster_counter #(.FRAME_LINE(FRAME_LINE)) u_count (
      .clk         (clk),
      .rst_n       (rst_n),
      .lines_m1    (cfg_q.lines_m1),
      .dots_m1     (cfg_q.dots_m1),
      .interlace   (cfg_q.interlace),
      .geo_wr      (geo_wr),
      .line        (line_q),
      .pos         (pos_q),
      .field       (field_q),
      .frame_start (frame_start)
   );

   raster_status #(.BACK_PORCH(BACK_PORCH), .HS_UNIT(HS_UNIT)) u_stat (
      .line     (line_q),
      .pos      (pos_q),
      .field    (field_q),
      .dots_m1  (cfg_q.dots_m1),
      .vs_lines (cfg_q.vs_lines),
      .hs_code  (cfg_q.hs_code),
      .fp_code  (cfg_q.fp_code),
      .status   (status_raw)
   );

   generate
      if (STATUS_REG) begin : g_status_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) status_word <= '0;
            else        status_word <= status_raw;
         end
      end else begin : g_status_comb
         assign status_word = status_raw;
      end
   endgenerate
endmodule

// File: rtl/raster_sync_checker.sv
module raster_sync_checker #(
   parameter int ADDR_W     = 3,
   parameter int FRAME_LINE = 42,
   parameter bit STATUS_REG = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [9:0]        line,
   input logic [9:0]        pos,
   input logic              field,
   input logic              interlace,
   input logic [3:0]        vs_lines,
   input logic [13:0]       status,
   input logic              frame_start
);
   // R4: geometry write restarts the dot count, keeps line and field
   assert_geo_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == '0) |=> (pos == '0 && $stable(line) && $stable(field)));

   // R3: field only flips at frame wrap with interlace on
   assert_field_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(field) |-> ($past(interlace) && line == '0 && pos == '0));

   // R2: line steps by one or returns to zero
   assert_line_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(line) |-> (line == '0 || line == $past(line) + 10'd1));

   // R8: pulse sits on the marked line at dot 0
   assert_frame_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |-> (line == 10'(FRAME_LINE) && pos == '0));

   // R8: pulse is a single cycle
   assert_frame_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> !frame_start);

   generate
      if (!STATUS_REG) begin : g_status_chk
         // R5: line and field in the low status bits
         assert_status_pos_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (status[9:0] == line && status[10] == field));

         // R7: mismatched parity above the sync lines shows only hsync released
         assert_quiet_lines_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (line[0] != field && line < 10'(vs_lines)) |-> (status[13:11] == 3'b010));
      end
   endgenerate
endmodule

bind raster_sync_timer raster_sync_checker #(
   .ADDR_W     (ADDR_W),
   .FRAME_LINE (FRAME_LINE),
   .STATUS_REG (STATUS_REG)
) u_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .wr_addr     (wr_addr),
   .line        (line_q),
   .pos         (pos_q),
   .field       (field_q),
   .interlace   (cfg_q.interlace),
   .vs_lines    (cfg_q.vs_lines),
   .status      (status_word),
   .frame_start (frame_start)
);

// File: tb/raster_sync_timer_bench.sv
module raster_sync_timer_bench;
   localparam int CLK_PERIOD = 10;
   localparam int BP         = 8;
   localparam int MARK       = 42;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [13:0] status_word;
   logic        frame_start;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   raster_sync_timer #(.BACK_PORCH(BP)) u_raster_sync_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data),
      .status_word (status_word),
      .frame_start (frame_start)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // behavioural reference model
   int m_line = 0, m_pos = 0, m_field = 0, m_fs = 0;
   int c_lm1 = 624, c_dm1 = 863, c_vs = 5, c_hs = 63, c_fp = 0, c_il = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_line = 0; m_pos = 0; m_field = 0; m_fs = 0;
         c_lm1 = 624; c_dm1 = 863; c_vs = 5; c_hs = 63; c_fp = 0; c_il = 0;
      end else begin
         int old_line, old_field;
         old_line = m_line; old_field = m_field;
         m_fs = 0;
         if (m_pos >= c_dm1) begin
            m_pos = 0;
            if (m_line >= c_lm1) begin
               m_line = 0;
               if (c_il != 0) m_field = 1 - m_field;
            end else m_line = m_line + 1;
            if (m_line == MARK) m_fs = 1;
         end else m_pos = m_pos + 1;
         if (wr_en) begin
            case (wr_addr)
               3'd0: begin
                  c_lm1 = int'(wr_data[25:16]); c_dm1 = int'(wr_data[9:0]);
                  m_pos = 0; m_line = old_line; m_field = old_field; m_fs = 0;
               end
               3'd1: c_il = int'(wr_data[4]);
               3'd2: begin c_vs = int'(wr_data[11:8]); c_hs = int'(wr_data[6:0]); end
               3'd3: c_fp = int'(wr_data[9:0]);
               default: ;
            endcase
         end
      end
   end

   function automatic int exp_status();
      int s;
      s = m_line | (m_field << 10);
      if ((m_line % 2) == m_field) begin
         if (m_pos > (c_hs + 1) * 2) s |= (1 << 12);
         if (m_line >= c_vs) begin
            s |= (1 << 13);
            if (m_pos > c_fp + 1) s |= (1 << 11);
         end
      end else begin
         if (m_line >= c_vs) begin
            s |= (3 << 12);
            if (m_pos + BP < c_dm1 + 1) s |= (1 << 11);
         end else s |= (1 << 12);
      end
      return s;
   endfunction

   task automatic check(input string tag, input int act, input int expv);
      tests++;
      if (act != expv) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, expv, $time);
      end
   endtask

   // per-cycle comparison and event counters
   int fs_count = 0, act_match = 0, act_mis = 0;
   always @(negedge clk) begin
      if (rst_n && !done) begin
         int e;
         e = exp_status();
         check("R2 R5 line/field", int'(status_word[10:0]), e & 32'h7FF);
         if ((m_line % 2) == m_field)
            check("R6 flags", int'(status_word[13:11]), (e >> 11) & 7);
         else
            check("R7 flags", int'(status_word[13:11]), (e >> 11) & 7);
         check("R8 frame_start", int'(frame_start), m_fs);
         if (frame_start) fs_count++;
         if (status_word[11]) begin
            if ((m_line % 2) == m_field) act_match++;
            else act_mis++;
         end
      end
   end

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic run(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      fails++;
      $display("FAIL R2 watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 status in reset", int'(status_word), 0);
      check("R1 frame_start in reset", int'(frame_start), 0);
      rst_n = 1'b1;

      // R1 defaults: 864 dots per line, vsync count 5
      run(864 * 3 + 10);
      check("R1 default geometry status", int'(status_word), 32'h1003);

      // R4 geometry rewrite keeps the line
      wr(3'd2, (32'd3 << 8) | 32'd4);
      wr(3'd3, 32'd6);
      wr(3'd0, (32'd49 << 16) | 32'd39);
      check("R4 line kept on geometry write", int'(status_word[9:0]), 3);
      run(39);
      check("R4 dot restart, line still held", int'(status_word[9:0]), 3);
      run(1);
      check("R4 line advances after full new line", int'(status_word[9:0]), 4);

      // R8 three frames, R3 no interlace
      fs_count = 0; act_match = 0; act_mis = 0;
      run(6000);
      check("R8 pulses in three frames", fs_count, 3);
      check("R3 field held without interlace", int'(status_word[10]), 0);
      check("R6 active seen on matching lines", int'(act_match > 0), 1);
      check("R7 active seen on other lines", int'(act_mis > 0), 1);

      // R3 interlace on, one wrap
      wr(3'd1, 32'h0000_0010);
      run(2000);
      check("R3 field flips at wrap", int'(status_word[10]), 1);
      wr(3'd1, 32'hFFFF_FFEF);
      run(4000);
      check("R3 field holds after interlace off", int'(status_word[10]), 1);

      // R9 writes to unused indices
      wr(3'd4, 32'h0);
      wr(3'd5, 32'h0000_0010);
      wr(3'd7, 32'hFFFF_FFFF);
      fs_count = 0;
      run(2000);
      check("R9 ignored writes keep geometry", fs_count, 1);
      check("R9 ignored writes keep status", int'(status_word), exp_status());

      // R8/R7 short frame, line shorter than back porch
      wr(3'd1, 32'h0000_0010);
      wr(3'd0, (32'd9 << 16) | 32'd5);
      fs_count = 0; act_mis = 0;
      run(1200);
      check("R8 no pulse in short frame", fs_count, 0);
      check("R7 no active when porch exceeds line", act_mis, 0);

      // R6/R7 large vsync count, narrow hsync
      wr(3'd2, (32'd15 << 8) | 32'd0);
      wr(3'd0, (32'd19 << 16) | 32'd5);
      run(1200);
      check("R5 final status matches model", int'(status_word), exp_status());

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule